// File: doc/BRIEF.md
# Bus Watch Timeout Monitor

This block guards a processor bus against accesses that are never answered. While the active-low data-enable input shows a transfer in progress and the active-low ready input has not been returned, a small counter advances once per clock. Each returned ready restarts the count, so every data phase of a burst gets its own full allowance. Deasserting data enable ends the access and also restarts the count.

When the count reaches a programmable limit, the block drives an active-low bus error output for one clock, provided the watch is enabled. The processor can then abandon the access instead of waiting forever. After an expiry the counter stays frozen for the rest of that access, so one stalled transfer produces exactly one error pulse. Reset leaves the output deasserted. The enable input is sampled only in the cycle in which the count expires.

Top module: `bus_watch_mon`

## Requirements
- R1: While reset is high, and on the first clock after it, `berr_n` is 1.
- R2: With `watch_en`=1, `limit`=L, `rdy_n`=1 and `den_n`=0 sampled at consecutive edges 1, 2, ... of an access, `berr_n` is 0 exactly in the cycle after edge L+1.
- R3: Every low phase of `berr_n` lasts exactly one clock cycle.
- R4: After an expiry, `berr_n` stays 1 for as long as `den_n` stays 0 with `rdy_n`=1.
- R5: When `rdy_n`=0 is sampled at edge j of an access, the count restarts from zero. With no further ready, the next expiry shows `berr_n`=0 after edge j+L+1.
- R6: When `den_n`=1 is sampled at edge j, the count restarts from zero. If `den_n` is then 0 again, the expiry falls after edge j+L+1.
- R7: With `watch_en`=0 at the expiry edge, `berr_n` stays 1.
- R8: `limit`=0 gives the error after the first edge that samples the access. `limit`=31, the 5-bit maximum, gives it after edge 32.
- R9: If `rdy_n`=0 is sampled at the same edge at which the count would expire, ready wins: no error is raised and the count restarts.
- R10: Enabling the watch only after an expiry, while the access is still held, raises no error. Enabling it exactly at the expiry edge does raise one.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| den_n | input | 1 | Data enable, active low: access in progress |
| rdy_n | input | 1 | Ready, active low: data phase completed |
| watch_en | input | 1 | Bus watch enable |
| limit | input | 5 | Timeout count limit |
| berr_n | output | 1 | Bus error, active low, registered |

## Verification
Two events can meet at one edge: a ready return and a count that has just reached its limit (R9). Enable changes can also land on the expiry edge (R10). The bench places `rdy_n`=0 at precisely the edge where the count would expire. It then expects no pulse there and a fresh pulse L+1 edges later. In the same way, `watch_en` is raised at the expiry edge in one run and two edges later in another, and the bench checks that the pulse appears only in the first run.

// File: rtl/bw_pkg.sv
package bw_pkg;
  localparam int BW_CNT_W = 5;

  typedef enum logic [1:0] {
    BW_IDLE  = 2'd0,
    BW_COUNT = 2'd1,
    BW_HOLD  = 2'd2
  } bw_state_e;
endpackage

// File: rtl/bw_counter.sv
module bw_counter #(
  parameter int W = 5
) (
  input  logic         clk,
  input  logic         rst,
  input  logic         clr,
  input  logic         inc,
  input  logic [W-1:0] limit,
  output logic         at_limit
);
  logic [W-1:0] count;

  always_ff @(posedge clk) begin
    if (rst || clr) begin
      count <= '0;
    end else if (inc) begin
      count <= count + 1'b1;
    end
  end

  assign at_limit = (count == limit);
endmodule

// File: rtl/bw_ctrl.sv
module bw_ctrl
  import bw_pkg::*;
(
  input  logic clk,
  input  logic rst,
  input  logic den_act,
  input  logic rdy_act,
  input  logic at_limit,
  output logic cnt_clr,
  output logic cnt_inc,
  output logic expire
);
  bw_state_e state, state_nx;
  logic      waiting;

  assign waiting = den_act && !rdy_act && (state != BW_HOLD);
  assign cnt_clr = !den_act || rdy_act;
  assign cnt_inc = waiting && !at_limit;
  assign expire  = waiting && at_limit;

  always_comb begin
    state_nx = state;
    if (!den_act) begin
      state_nx = BW_IDLE;
    end else if (rdy_act) begin
      state_nx = BW_COUNT;
    end else begin
      unique case (state)
        BW_IDLE, BW_COUNT: state_nx = at_limit ? BW_HOLD : BW_COUNT;
        BW_HOLD:           state_nx = BW_HOLD;
        default:           state_nx = BW_IDLE;
      endcase
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      state <= BW_IDLE;
    end else begin
      state <= state_nx;
    end
  end
endmodule

// File: rtl/bw_err_out.sv
module bw_err_out (
  input  logic clk,
  input  logic rst,
  input  logic fire,
  input  logic enable,
  output logic err_n
);
  always_ff @(posedge clk) begin
    if (rst) begin
      err_n <= 1'b1;
    end else begin
      err_n <= !(fire && enable);
    end
  end
endmodule

// File: rtl/bus_watch_mon.sv
module bus_watch_mon
  import bw_pkg::*;
#(
  parameter int CNT_W = BW_CNT_W
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             den_n,
  input  logic             rdy_n,
  input  logic             watch_en,
  input  logic [CNT_W-1:0] limit,
  output logic             berr_n
);
  logic cnt_clr, cnt_inc, at_limit, expire;

  bw_ctrl u_ctrl (
    .clk      (clk),
    .rst      (rst),
    .den_act  (!den_n),
    .rdy_act  (!rdy_n),
    .at_limit (at_limit),
    .cnt_clr  (cnt_clr),
    .cnt_inc  (cnt_inc),
    .expire   (expire)
  );

  bw_counter #(.W(CNT_W)) u_cnt (
    .clk      (clk),
    .rst      (rst),
    .clr      (cnt_clr),
    .inc      (cnt_inc),
    .limit    (limit),
    .at_limit (at_limit)
  );

  bw_err_out u_err (
    .clk    (clk),
    .rst    (rst),
    .fire   (expire),
    .enable (watch_en),
    .err_n  (berr_n)
  );
endmodule

// File: rtl/bw_watch_chk.sv
module bw_watch_chk (
  input logic clk,
  input logic rst,
  input logic den_n,
  input logic rdy_n,
  input logic watch_en,
  input logic berr_n
);
  logic fired;

  always_ff @(posedge clk) begin
    if (rst || den_n || !rdy_n) begin
      fired <= 1'b0;
    end else if (!berr_n) begin
      fired <= 1'b1;
    end
  end

  AST_RESET_QUIET: assert property (@(posedge clk) rst |=> berr_n); // R1
  AST_ERR_NEEDS_ACCESS: assert property (@(posedge clk) disable iff (rst)
    !berr_n |-> $past(!den_n && rdy_n)); // R2
  AST_ERR_ONE_CYCLE: assert property (@(posedge clk) disable iff (rst)
    !berr_n |=> berr_n); // R3
  AST_ONE_PER_ACCESS: assert property (@(posedge clk) disable iff (rst)
    fired |-> berr_n); // R4
  AST_ERR_NEEDS_EN: assert property (@(posedge clk) disable iff (rst)
    $fell(berr_n) |-> $past(watch_en)); // R7
endmodule

bind bus_watch_mon bw_watch_chk u_chk (
  .clk      (clk),
  .rst      (rst),
  .den_n    (den_n),
  .rdy_n    (rdy_n),
  .watch_en (watch_en),
  .berr_n   (berr_n)
);

// File: tb/tb_bus_watch_mon.sv
`timescale 1ns/1ps
module tb_bus_watch_mon;
  logic       clk = 1'b0;
  logic       rst = 1'b1;
  logic       den_n = 1'b1;
  logic       rdy_n = 1'b1;
  logic       watch_en = 1'b0;
  logic [4:0] limit = 5'd0;
  logic       berr_n;
  int checks = 0;
  int fails  = 0;
  bit done   = 1'b0;

  always #2.5 clk = ~clk;

  bus_watch_mon dut (
    .clk(clk), .rst(rst), .den_n(den_n), .rdy_n(rdy_n),
    .watch_en(watch_en), .limit(limit), .berr_n(berr_n)
  );

  task automatic chk(input string req, input logic act, input logic exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s: berr_n=%b expected %b at %0t", req, act, exp, $time);
    end
  endtask

  // Drives one access of n edges. den_n is high only at den_edge, rdy_n is
  // low only at rdy_edge, watch_en is 1 from en_edge on. A low output is
  // expected only after edges exp_a and exp_b.
  task automatic run_access(input string req, input int lim, input int en_edge,
                            input int rdy_edge, input int den_edge, input int n,
                            input int exp_a, input int exp_b);
    limit = 5'(lim);
    for (int k = 1; k <= n; k++) begin
      @(negedge clk);
      watch_en = (k >= en_edge);
      rdy_n    = (k == rdy_edge) ? 1'b0 : 1'b1;
      den_n    = (k == den_edge) ? 1'b1 : 1'b0;
      @(posedge clk);
      #1;
      chk(req, berr_n, !((k == exp_a) || (k == exp_b)));
    end
    @(negedge clk);
    den_n = 1'b1;
    rdy_n = 1'b1;
    @(posedge clk);
    #1;
    chk(req, berr_n, 1'b1);
  endtask

  task automatic t_reset();
    rst = 1'b1;
    repeat (3) @(posedge clk);
    #1;
    chk("R1", berr_n, 1'b1);
    @(negedge clk);
    rst = 1'b0;
    @(posedge clk);
    #1;
    chk("R1", berr_n, 1'b1);
  endtask

  // R2 R3 R4: pulse after edge 6, then silence while held
  task automatic t_basic();   run_access("R2", 5, 1, 0, 0, 14, 6, 0);   endtask
  task automatic t_lim_zero(); run_access("R8", 0, 1, 0, 0, 5, 1, 0);   endtask
  task automatic t_lim_max(); run_access("R8", 31, 1, 0, 0, 34, 32, 0); endtask
  task automatic t_ready();   run_access("R5", 4, 1, 3, 0, 10, 8, 0);   endtask
  task automatic t_den_gap(); run_access("R6", 4, 1, 0, 3, 10, 8, 0);   endtask
  task automatic t_disabled(); run_access("R7", 2, 99, 0, 0, 8, 0, 0);  endtask
  // R9: expiry due at edge 4 is cancelled by ready at edge 4
  task automatic t_collide(); run_access("R9", 3, 1, 4, 0, 9, 8, 0);    endtask
  task automatic t_en_late(); run_access("R10", 2, 5, 0, 0, 9, 0, 0);   endtask
  task automatic t_en_edge(); run_access("R10", 2, 3, 0, 0, 6, 3, 0);   endtask

  task automatic t_reset_hold();
    limit = 5'd1;
    @(negedge clk);
    watch_en = 1'b1;
    den_n = 1'b0;
    repeat (2) @(posedge clk);
    #1;
    chk("R2", berr_n, 1'b0);
    @(negedge clk);
    rst = 1'b1;
    @(posedge clk);
    #1;
    chk("R1", berr_n, 1'b1);
    @(negedge clk);
    rst = 1'b0;
    den_n = 1'b1;
    @(posedge clk);
    #1;
    chk("R1", berr_n, 1'b1);
  endtask

  initial begin
    t_reset();
    t_basic();
    t_lim_zero();
    t_lim_max();
    t_ready();
    t_den_gap();
    t_disabled();
    t_collide();
    t_en_late();
    t_en_edge();
    t_reset_hold();
    if (!done) begin
      done = 1'b1;
      $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
      $finish;
    end
  end

  initial begin
    #100000;
    if (!done) begin
      done = 1'b1;
      checks++;
      fails++;
      $display("FAIL watchdog: run hung, actual running expected finished");
      $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
      $finish;
    end
  end
endmodule